// File: doc/BRIEF.md
# Page-Confined Sequential Miss Stream Prefetcher

This block watches the addresses of cache misses and finds sequential access streams inside 4 KB pages. It keeps up to eight stream entries at once, one per page. An entry becomes active when a miss falls in the same page as the previous miss recorded for that page, and the two missed 64-byte blocks are one to three blocks apart, which is less than 256 bytes. An active stream then asks for the block just beyond the newest miss. The sign of the block step gives the direction: a step forward asks for the next higher block, and a step backward asks for the next lower one.

Requests leave through a valid/ready port. They are offered only while the memory-busy input is low. A pending request is held inside the block while memory is busy, and it is offered again once memory is free. A request never crosses the page boundary. A miss to an untracked page takes a free entry, or the least recently used entry when all eight are in use. Data return and cache fill are handled elsewhere.

Top module: `miss_stream_prefetcher`

## Requirements
- R1: At most 8 entries are tracked, and no two valid entries hold the same page number (address bits 31:12).
- R2: A request is made only when a miss lands in a tracked page whose previous miss was 1, 2 or 3 blocks away (block index = address bits 11:6). A distance of 0 blocks, or of 4 or more blocks, makes no request.
- R3: On activation, pf_addr is the page of the miss with block index miss+1 for a positive step or miss-1 for a negative step, and bits 5:0 are zero. pf_valid rises in the cycle after the clock edge that samples the miss.
- R4: No request leaves the page. A forward step that lands on block 63 makes no request, and neither does a backward step that lands on block 0.
- R5: While mem_busy is 1, pf_valid is 0 and pending requests are kept. After mem_busy falls, the kept request is offered.
- R6: pf_valid and pf_addr hold steady until pf_ready is seen. Once a request is accepted it is not offered again.
- R7: A miss to an untracked page with all 8 entries valid replaces the least recently used entry. A miss to a tracked page counts as a use of that entry.
- R8: A miss on a block that was already prefetched moves the stream forward: the next request is the following block, and the prefetched block is never requested again.
- R9: Pending requests from different streams are all offered, one per accepted handshake.
- R10: A miss in an active stream's page that does not meet the R2 distance rule deactivates that stream and cancels its pending request.
- R11: After reset pf_valid is 0 and no page is tracked, so the first miss to any page makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| mem_busy | input | 1 | Memory has no spare bandwidth this cycle |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
The bench probes the distance window at both edges. A gap of exactly four blocks, or a repeat of the same block, must stay silent; a design that used a less-than-or-equal test, or that counted zero as a step, would issue a request there. Streams that start next to the top or the bottom of a page check that no request crosses the boundary, which a design with a plain increment would do. Further directed cases cover the least recently used victim after a re-touch, a stream moving forward after a miss on an address it already prefetched, cancellation by a far miss, and holding requests while memory is busy; a design that got any of these wrong would evict the wrong page, repeat a request, or lose or leak a request.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int ADDR_W     = 32;
    localparam int BLK_BYTES  = 64;
    localparam int PAGE_BYTES = 4096;
    localparam int WIN_BYTES  = 256;
    localparam int N_STREAMS  = 8;

    localparam int OFS_W    = $clog2(BLK_BYTES);
    localparam int PG_W     = $clog2(PAGE_BYTES);
    localparam int IDX_W    = PG_W - OFS_W;
    localparam int PN_W     = ADDR_W - PG_W;
    localparam int WIN_BLKS = WIN_BYTES / BLK_BYTES;
    localparam int SID_W    = $clog2(N_STREAMS);

    typedef logic [PN_W-1:0]  page_t;
    typedef logic [IDX_W-1:0] bidx_t;
    typedef logic [SID_W-1:0] sid_t;

    typedef enum logic {DIR_UP, DIR_DOWN} dir_e;

    typedef struct packed {
        logic  valid;
        page_t page;
        bidx_t last;
        logic  active;
        dir_e  dir;
        logic  pend;
        bidx_t target;
    } stream_t;

    typedef struct packed {
        logic  in_win;
        logic  in_page;
        dir_e  dir;
        bidx_t next;
    } step_t;

    // Judge a new miss block against the previous one in the same page.
    function automatic step_t eval_step(bidx_t prev, bidx_t cur);
        step_t r;
        logic signed [IDX_W:0] d;
        logic [IDX_W:0] mag;
        logic up;
        d   = $signed({1'b0, cur}) - $signed({1'b0, prev});
        up  = (d > 0);
        mag = up ? d : -d;
        r.in_win  = (d != 0) && (mag < (IDX_W+1)'(WIN_BLKS));
        r.dir     = up ? DIR_UP : DIR_DOWN;
        r.in_page = up ? (cur != '1) : (cur != '0);
        r.next    = up ? cur + 1'b1 : cur - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pfd_lru.sv
module pfd_lru
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic touch_valid,
    input  sid_t touch_sel,
    output sid_t victim
);
    sid_t rank [N_STREAMS];
    logic [N_STREAMS-1:0] is_oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_STREAMS; i++) rank[i] <= sid_t'(i);
        end else if (touch_valid) begin
            for (int i = 0; i < N_STREAMS; i++) begin
                if (sid_t'(i) == touch_sel)
                    rank[i] <= sid_t'(N_STREAMS-1);
                else if (rank[i] > rank[touch_sel])
                    rank[i] <= rank[i] - 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            is_oldest[i] = (rank[i] == '0);
            if (is_oldest[i]) victim = sid_t'(i);
        end
    end

    // R7
    lru_single_victim_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(is_oldest));
endmodule

// File: rtl/pfd_issue_arb.sv
module pfd_issue_arb
    import pfd_pkg::*;
(
    input  logic [N_STREAMS-1:0] pend,
    output logic                 any,
    output sid_t                 sel
);
    always_comb begin
        any = |pend;
        sel = '0;
        for (int i = N_STREAMS-1; i >= 0; i--)
            if (pend[i]) sel = sid_t'(i);
    end
endmodule

// File: rtl/pfd_stream_table.sv
module pfd_stream_table
    import pfd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 miss_valid,
    input  page_t                miss_page,
    input  bidx_t                miss_blk,
    input  sid_t                 victim,
    input  logic                 issue_fire,
    input  sid_t                 issue_sel,
    output logic                 touch_valid,
    output sid_t                 touch_sel,
    output logic [N_STREAMS-1:0] pend,
    output logic [ADDR_W-1:0]    issue_addr
);
    stream_t tbl [N_STREAMS];
    stream_t nxt [N_STREAMS];
    logic    hit_any;
    sid_t    hit_sel;
    step_t   st;

    always_comb begin
        hit_any = 1'b0;
        hit_sel = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (tbl[i].valid && tbl[i].page == miss_page) begin
                hit_any = 1'b1;
                hit_sel = sid_t'(i);
            end
        end
        touch_valid = miss_valid;
        touch_sel   = hit_any ? hit_sel : victim;
    end

    always_comb begin
        st = eval_step(tbl[hit_sel].last, miss_blk);
        for (int i = 0; i < N_STREAMS; i++) begin
            nxt[i] = tbl[i];
            if (issue_fire && issue_sel == sid_t'(i)) nxt[i].pend = 1'b0;
            if (miss_valid && touch_sel == sid_t'(i)) begin
                nxt[i].valid = 1'b1;
                nxt[i].page  = miss_page;
                nxt[i].last  = miss_blk;
                if (hit_any && st.in_win && st.in_page) begin
                    nxt[i].active = 1'b1;
                    nxt[i].dir    = st.dir;
                    nxt[i].pend   = 1'b1;
                    nxt[i].target = st.next;
                end else begin
                    nxt[i].active = 1'b0;
                    nxt[i].pend   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_STREAMS; i++) begin
            if (rst) tbl[i] <= '0;
            else     tbl[i] <= nxt[i];
        end
    end

    always_comb begin
        for (int i = 0; i < N_STREAMS; i++) pend[i] = tbl[i].pend;
        issue_addr = {tbl[issue_sel].page, tbl[issue_sel].target, OFS_W'(0)};
    end

    genvar gi, gj;
    generate
        for (gi = 0; gi < N_STREAMS; gi++) begin : g_ent
            // R3
            pend_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
                tbl[gi].pend |-> (tbl[gi].active && tbl[gi].valid));
            for (gj = gi + 1; gj < N_STREAMS; gj++) begin : g_pair
                // R1
                unique_page_chk: assert property (@(posedge clk) disable iff (rst)
                    (tbl[gi].valid && tbl[gj].valid) |-> (tbl[gi].page != tbl[gj].page));
            end
        end
    endgenerate
endmodule

// File: rtl/miss_stream_prefetcher.sv
module miss_stream_prefetcher
    import pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              mem_busy,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [N_STREAMS-1:0] pend;
    logic  any_pend, issue_fire, touch_valid;
    sid_t  issue_sel, touch_sel, victim;
    logic  unused_ofs;

    assign unused_ofs = ^miss_addr[OFS_W-1:0];
    assign pf_valid   = any_pend && !mem_busy;
    assign issue_fire = pf_valid && pf_ready;

    pfd_stream_table u_table (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_page  (miss_addr[ADDR_W-1:PG_W]),
        .miss_blk   (miss_addr[PG_W-1:OFS_W]),
        .victim     (victim),
        .issue_fire (issue_fire),
        .issue_sel  (issue_sel),
        .touch_valid(touch_valid),
        .touch_sel  (touch_sel),
        .pend       (pend),
        .issue_addr (pf_addr)
    );

    pfd_lru u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_valid(touch_valid),
        .touch_sel  (touch_sel),
        .victim     (victim)
    );

    pfd_issue_arb u_arb (
        .pend(pend),
        .any (any_pend),
        .sel (issue_sel)
    );

    // R6
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !miss_valid) |=> (pf_valid || mem_busy));
    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !miss_valid) |=> (!pf_valid || $stable(pf_addr)));
    // R5
    busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_busy && any_pend && !miss_valid) |=> any_pend);
endmodule

// File: tb/miss_stream_prefetcher_test.sv
module miss_stream_prefetcher_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        miss_valid = 0;
    logic [31:0] miss_addr = '0;
    logic        mem_busy = 0;
    logic        pf_ready = 0;
    logic        pf_valid;
    logic [31:0] pf_addr;
    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    miss_stream_prefetcher uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .mem_busy(mem_busy), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mk(int page, int blk);
        return (32'(page) << 12) | (32'(blk) << 6);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; miss_valid = 0; pf_ready = 0; mem_busy = 0;
        @(posedge clk); @(posedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic miss(int page, int blk, int ofs = 0);
        miss_valid = 1; miss_addr = mk(page, blk) | 32'(ofs);
        @(posedge clk); @(negedge clk); miss_valid = 0;
    endtask

    task automatic accept();
        pf_ready = 1; @(posedge clk); @(negedge clk); pf_ready = 0;
    endtask

    task automatic chk(string req, logic ev, logic [31:0] ea);
        n_run++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h", req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 reset", 0, 0);
        miss(3, 10);
        chk("R11 first miss", 0, 0);
    endtask

    task automatic t_up();
        do_reset();
        miss(5, 10, 7); miss(5, 12, 33);
        chk("R2 R3 ascending step 2", 1, mk(5, 13));
        accept();
        chk("R6 no repeat after accept", 0, 0);
    endtask

    task automatic t_window();
        do_reset();
        miss(6, 10); miss(6, 14);
        chk("R2 distance 4 blocks", 0, 0);
        miss(7, 20); miss(7, 20, 9);
        chk("R2 distance 0", 0, 0);
        miss(8, 20); miss(8, 23);
        chk("R2 distance 3", 1, mk(8, 24));
    endtask

    task automatic t_down();
        do_reset();
        miss(9, 20); miss(9, 18);
        chk("R3 descending", 1, mk(9, 17));
    endtask

    task automatic t_edge();
        do_reset();
        miss(10, 61); miss(10, 63);
        chk("R4 top of page", 0, 0);
        miss(11, 2); miss(11, 0);
        chk("R4 bottom of page", 0, 0);
    endtask

    task automatic t_busy_hold();
        do_reset();
        mem_busy = 1;
        miss(12, 10); miss(12, 11);
        chk("R5 busy blocks", 0, 0);
        @(posedge clk); @(negedge clk);
        chk("R5 busy still blocks", 0, 0);
        mem_busy = 0; #1;
        chk("R5 kept request offered", 1, mk(12, 12));
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R6 held without ready", 1, mk(12, 12));
    endtask

    task automatic t_advance();
        do_reset();
        miss(13, 10); miss(13, 11);
        chk("R8 first request", 1, mk(13, 12));
        accept();
        miss(13, 12);
        chk("R8 advance past prefetched", 1, mk(13, 13));
    endtask

    task automatic t_multi();
        logic [31:0] a0, a1;
        do_reset();
        miss(1, 4); miss(1, 5);
        miss(2, 8); miss(2, 9);
        n_run++;
        if (!pf_valid) begin n_fail++; $display("FAIL R9 first valid: valid=0 expected 1"); end
        a0 = pf_addr; accept();
        n_run++;
        if (!pf_valid) begin n_fail++; $display("FAIL R9 second valid: valid=0 expected 1"); end
        a1 = pf_addr; accept();
        n_run++;
        if (!((a0 == mk(1, 6) && a1 == mk(2, 10)) || (a0 == mk(2, 10) && a1 == mk(1, 6)))) begin
            n_fail++;
            $display("FAIL R9 set: got %h %h expected %h %h", a0, a1, mk(1, 6), mk(2, 10));
        end
        chk("R9 drained", 0, 0);
    endtask

    task automatic t_cancel();
        do_reset();
        miss(14, 10); miss(14, 11);
        chk("R10 pending", 1, mk(14, 12));
        miss(14, 30);
        chk("R10 cancelled", 0, 0);
    endtask

    task automatic t_lru();
        do_reset();
        for (int p = 0; p < 8; p++) miss(16 + p, 3);
        miss(16, 3);
        miss(24, 3);
        miss(17, 4);
        chk("R7 evicted page restarts", 0, 0);
        miss(16, 4);
        chk("R7 retouched page kept R1", 1, mk(16, 5));
    endtask

    initial begin
        while (cycles < 100000) begin @(posedge clk); cycles++; end
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_up();
        t_window();
        t_down();
        t_edge();
        t_busy_hold();
        t_advance();
        t_multi();
        t_cancel();
        t_lru();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule